// File: doc/BRIEF.md
# Dual-Direction Host Mailbox Interface

This block sits between an external host on a byte-wide synchronous bus and an embedded controller on a simple synchronous read/write port. Message bytes travel through two independent byte stores, one per direction. The host reaches both stores through a single data offset. A read at that offset drains the controller-to-host store and a write fills the host-to-controller store. Each direction has its own host-programmable index. That index steps by one after every data access, so a block transfer needs only its start index. To reach a random byte, the host rewrites the index first.

Next to the stores are a 16-bit control word per direction, split into low and high bytes, and a status byte per direction. Two interrupt flags complete the block. The host-side flag drives `h_irq` through a mask that resets to the masked state. The mask acts only on the output line: the flag can still be polled. The controller-side flag drives `c_irq` directly. Each flag is cleared by its own acknowledge bit.

Top module: `hmbx_top`

## Requirements
- R1: After a synchronous reset both indices, both control words and both status bytes read 0, the host mask (bit 2 of offset 0x0A) is 0, both interrupt flags are clear, and `h_irq` and `c_irq` are low.
- R2: A host write to offset 0x00 stores the byte at the host-to-controller index, which then advances by one. The controller reads that store with `c_addr[7]`=0 and `c_addr[6:0]` as the index. The read returns data one cycle after the strobe.
- R3: A host read of offset 0x00 returns the controller-to-host byte at the read index one cycle after the strobe, and the read index then advances by one. The controller fills that store with `c_addr[7]`=0 writes.
- R4: The read index sits at host offset 0x01 and the write index at 0x02. Both can be read and written directly, and the lower 6 bits of a written value are kept. A rewritten index selects the byte used by the next data access.
- R5: An index that advances from 60 or above becomes 0.
- R6: A host data write while the write index exceeds 60 changes no stored byte, and the index still advances to 0. A data read at an index above 60 returns 0 on either side.
- R7: The host writes the host-to-controller control word at 0x04 (low) and 0x05 (high), and the controller reads it at 0x82 and 0x83. The controller writes the other word at 0x80 and 0x81, and the host reads it at 0x06 and 0x07. Host writes to 0x06 and 0x07 have no effect.
- R8: A controller write to 0x84 stores the controller-to-host status byte, which the host reads at 0x08, and sets the host flag. A host write to 0x09 stores the host-to-controller status byte, which the controller reads at 0x85, and sets the controller flag.
- R9: Host offset 0x0A reads as the mask in bit 2 and the host flag in bit 0. Only bit 2 of a write there is kept. The flag sets regardless of the mask, and `h_irq` is high exactly when the flag and the mask are both 1.
- R10: A host write to 0x0B with bit 0 = 1 clears the host flag, and bit 0 = 0 leaves it unchanged. A controller status write in the same cycle keeps the flag set.
- R11: `c_irq` follows the controller flag. A controller write to 0x86 with bit 0 = 1 clears it, and a host status write in the same cycle keeps it set. A controller read of 0x86 returns the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 8 | Host register offset |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, valid the cycle after a read strobe |
| h_irq | output | 1 | Host interrupt line (flag AND mask) |
| c_en | input | 1 | Controller access strobe |
| c_we | input | 1 | Controller write (1) or read (0) |
| c_addr | input | 8 | Controller address: bit 7 = 0 mailbox index, bit 7 = 1 registers |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, valid the cycle after a read strobe |
| c_irq | output | 1 | Controller interrupt line |

## Verification
The bench first runs sequential bursts in both directions. These show that one data offset reaches two separate stores and that each index steps on its own. It then rewrites the indices for random access, which tells a reloaded index apart from one that keeps counting. Indices at 60, 62 and 63 exercise the wrap and the dropped out-of-range write. Last, acknowledges are issued alone, with bit 0 clear, and in the same cycle as a new event, which shows flag priority apart from plain clearing. The mask is toggled while a flag is pending, which shows the line gated apart from the polled bit.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

    localparam int BW = 8;

    typedef logic [BW-1:0] byte_t;

    typedef struct packed {
        logic  en;
        logic  we;
        byte_t addr;
        byte_t data;
    } acc_t;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } word_t;

    typedef enum logic {SRC_REG, SRC_MBOX} rsrc_e;

    // host-side offsets
    localparam byte_t HA_DATA     = 8'h00;
    localparam byte_t HA_RPTR     = 8'h01;
    localparam byte_t HA_WPTR     = 8'h02;
    localparam byte_t HA_H2C_LO   = 8'h04;
    localparam byte_t HA_H2C_HI   = 8'h05;
    localparam byte_t HA_C2H_LO   = 8'h06;
    localparam byte_t HA_C2H_HI   = 8'h07;
    localparam byte_t HA_C2H_STAT = 8'h08;
    localparam byte_t HA_H2C_STAT = 8'h09;
    localparam byte_t HA_MASK     = 8'h0A;
    localparam byte_t HA_ACK      = 8'h0B;

    // controller-side register offsets (bit 7 set)
    localparam byte_t CA_C2H_LO   = 8'h80;
    localparam byte_t CA_C2H_HI   = 8'h81;
    localparam byte_t CA_H2C_LO   = 8'h82;
    localparam byte_t CA_H2C_HI   = 8'h83;
    localparam byte_t CA_C2H_STAT = 8'h84;
    localparam byte_t CA_H2C_STAT = 8'h85;
    localparam byte_t CA_ACK      = 8'h86;

    localparam int MASK_BIT = 2;
    localparam int STA_BIT  = 0;

    function automatic bit in_store(input int unsigned idx, input int unsigned depth);
        return idx < depth;
    endfunction

endpackage

// File: rtl/hmbx_mem.sv
module hmbx_mem
    import hmbx_pkg::*;
#(
    parameter int DEPTH = 61,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  byte_t         wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output byte_t         rd_data
);
    localparam int AW   = $clog2(DEPTH);
    localparam int LAST = DEPTH - 1;

    byte_t cells [DEPTH];
    byte_t rd_q;

    logic wr_ok, rd_ok;
    assign wr_ok = in_store(int'(wr_idx), DEPTH);
    assign rd_ok = in_store(int'(rd_idx), DEPTH);

    always_ff @(posedge clk) begin
        if (wr_en && wr_ok) begin
            cells[wr_idx[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_ok ? cells[rd_idx[AW-1:0]] : '0;
        end
    end

    assign rd_data = rd_q;

    // R6: reads beyond the last cell return zero
    a_r6_oob_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_idx > IW'(LAST)) |=> (rd_data == '0));

endmodule

// File: rtl/hmbx_ptr.sv
module hmbx_ptr #(
    parameter int DEPTH = 61,
    parameter int PW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    localparam int LAST = DEPTH - 1;

    logic [PW-1:0] ptr_q, ptr_inc;

    assign ptr_inc = (ptr_q >= PW'(LAST)) ? '0 : ptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (step) begin
            ptr_q <= ptr_inc;
        end
    end

    assign ptr = ptr_q;

    // R5: stepping from the last index or beyond lands on zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr_q >= PW'(LAST)) |=> (ptr_q == '0));

    // R2: an in-range step moves forward by exactly one
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr_q < PW'(LAST)) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R4: a load takes the written value
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (ptr_q == $past(load_val)));

endmodule

// File: rtl/hmbx_irq.sv
module hmbx_irq #(
    parameter bit GATED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic ack_i,
    input  logic msk_we,
    input  logic msk_d,
    output logic sta_o,
    output logic msk_o,
    output logic irq_o
);
    logic sta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_q <= 1'b0;
        end else if (evt_i) begin
            sta_q <= 1'b1;
        end else if (ack_i) begin
            sta_q <= 1'b0;
        end
    end

    assign sta_o = sta_q;

    generate
        if (GATED) begin : g_mask
            logic msk_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    msk_q <= 1'b0;
                end else if (msk_we) begin
                    msk_q <= msk_d;
                end
            end
            assign msk_o = msk_q;
            assign irq_o = sta_q & msk_q;

            // R9: a cleared mask keeps the line quiet
            a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
                !msk_q |-> !irq_o);
        end else begin : g_plain
            logic unused_mask_in;
            assign unused_mask_in = msk_we ^ msk_d;
            assign msk_o = 1'b1;
            assign irq_o = sta_q;
        end
    endgenerate

    // R10 / R11: a new event always leaves the flag set
    a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> sta_o);

    // R10 / R11: an acknowledge alone clears the flag
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !evt_i) |=> !sta_o);

endmodule

// File: rtl/hmbx_top.sv
module hmbx_top
    import hmbx_pkg::*;
#(
    parameter int DEPTH = 61
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       h_cs,
    input  logic       h_we,
    input  logic [7:0] h_addr,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata,
    output logic       h_irq,
    input  logic       c_en,
    input  logic       c_we,
    input  logic [7:0] c_addr,
    input  logic [7:0] c_wdata,
    output logic [7:0] c_rdata,
    output logic       c_irq
);
    localparam int PW = $clog2(DEPTH);
    localparam int IW = BW;

    acc_t hreq, creq;
    assign hreq = '{en: h_cs, we: h_we, addr: h_addr, data: h_wdata};
    assign creq = '{en: c_en, we: c_we, addr: c_addr, data: c_wdata};

    logic hw, hr, cw, cr;
    assign hw = hreq.en &  hreq.we;
    assign hr = hreq.en & ~hreq.we;
    assign cw = creq.en &  creq.we;
    assign cr = creq.en & ~creq.we;

    logic h_data_wr, h_data_rd, c_mb, c_mb_wr, c_mb_rd;
    assign h_data_wr = hw && (hreq.addr == HA_DATA);
    assign h_data_rd = hr && (hreq.addr == HA_DATA);
    assign c_mb      = ~creq.addr[7];
    assign c_mb_wr   = cw & c_mb;
    assign c_mb_rd   = cr & c_mb;

    // indices
    logic [PW-1:0] rptr, wptr;

    hmbx_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
        .clk(clk), .rst(rst),
        .load(hw && (hreq.addr == HA_RPTR)),
        .load_val(hreq.data[PW-1:0]),
        .step(h_data_rd),
        .ptr(rptr)
    );

    hmbx_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
        .clk(clk), .rst(rst),
        .load(hw && (hreq.addr == HA_WPTR)),
        .load_val(hreq.data[PW-1:0]),
        .step(h_data_wr),
        .ptr(wptr)
    );

    logic [IW-1:0] wptr_x, rptr_x, cidx_x;
    assign wptr_x = {{(IW-PW){1'b0}}, wptr};
    assign rptr_x = {{(IW-PW){1'b0}}, rptr};
    assign cidx_x = {1'b0, creq.addr[6:0]};

    // two separate stores
    byte_t h2c_rd, c2h_rd;

    hmbx_mem #(.DEPTH(DEPTH), .IW(IW)) u_h2c (
        .clk(clk), .rst(rst),
        .wr_en(h_data_wr), .wr_idx(wptr_x), .wr_data(hreq.data),
        .rd_en(c_mb_rd), .rd_idx(cidx_x), .rd_data(h2c_rd)
    );

    hmbx_mem #(.DEPTH(DEPTH), .IW(IW)) u_c2h (
        .clk(clk), .rst(rst),
        .wr_en(c_mb_wr), .wr_idx(cidx_x), .wr_data(creq.data),
        .rd_en(h_data_rd), .rd_idx(rptr_x), .rd_data(c2h_rd)
    );

    // control words and status bytes
    word_t h2c_ctl, c2h_ctl;
    byte_t h2c_stat, c2h_stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            h2c_ctl  <= '0;
            c2h_ctl  <= '0;
            h2c_stat <= '0;
            c2h_stat <= '0;
        end else begin
            if (hw) begin
                case (hreq.addr)
                    HA_H2C_LO:   h2c_ctl.lo <= hreq.data;
                    HA_H2C_HI:   h2c_ctl.hi <= hreq.data;
                    HA_H2C_STAT: h2c_stat   <= hreq.data;
                    default: ;
                endcase
            end
            if (cw) begin
                case (creq.addr)
                    CA_C2H_LO:   c2h_ctl.lo <= creq.data;
                    CA_C2H_HI:   c2h_ctl.hi <= creq.data;
                    CA_C2H_STAT: c2h_stat   <= creq.data;
                    default: ;
                endcase
            end
        end
    end

    // interrupt flags
    logic h_sta, h_msk, c_sta, c_msk_unused;

    hmbx_irq #(.GATED(1'b1)) u_hirq (
        .clk(clk), .rst(rst),
        .evt_i(cw && (creq.addr == CA_C2H_STAT)),
        .ack_i(hw && (hreq.addr == HA_ACK) && hreq.data[0]),
        .msk_we(hw && (hreq.addr == HA_MASK)),
        .msk_d(hreq.data[MASK_BIT]),
        .sta_o(h_sta), .msk_o(h_msk), .irq_o(h_irq)
    );

    hmbx_irq #(.GATED(1'b0)) u_cirq (
        .clk(clk), .rst(rst),
        .evt_i(hw && (hreq.addr == HA_H2C_STAT)),
        .ack_i(cw && (creq.addr == CA_ACK) && creq.data[0]),
        .msk_we(1'b0),
        .msk_d(1'b0),
        .sta_o(c_sta), .msk_o(c_msk_unused), .irq_o(c_irq)
    );

    // host read path
    byte_t mask_view, h_mux, h_reg_q;
    rsrc_e h_src_q;

    always_comb begin
        mask_view = '0;
        mask_view[MASK_BIT] = h_msk;
        mask_view[STA_BIT]  = h_sta;
    end

    always_comb begin
        case (hreq.addr)
            HA_RPTR:     h_mux = rptr_x;
            HA_WPTR:     h_mux = wptr_x;
            HA_H2C_LO:   h_mux = h2c_ctl.lo;
            HA_H2C_HI:   h_mux = h2c_ctl.hi;
            HA_C2H_LO:   h_mux = c2h_ctl.lo;
            HA_C2H_HI:   h_mux = c2h_ctl.hi;
            HA_C2H_STAT: h_mux = c2h_stat;
            HA_H2C_STAT: h_mux = h2c_stat;
            HA_MASK:     h_mux = mask_view;
            default:     h_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_reg_q <= '0;
            h_src_q <= SRC_REG;
        end else if (hr) begin
            h_reg_q <= h_mux;
            h_src_q <= (hreq.addr == HA_DATA) ? SRC_MBOX : SRC_REG;
        end
    end

    assign h_rdata = (h_src_q == SRC_MBOX) ? c2h_rd : h_reg_q;

    // controller read path
    byte_t c_mux, c_reg_q;
    rsrc_e c_src_q;

    always_comb begin
        case (creq.addr)
            CA_C2H_LO:   c_mux = c2h_ctl.lo;
            CA_C2H_HI:   c_mux = c2h_ctl.hi;
            CA_H2C_LO:   c_mux = h2c_ctl.lo;
            CA_H2C_HI:   c_mux = h2c_ctl.hi;
            CA_C2H_STAT: c_mux = c2h_stat;
            CA_H2C_STAT: c_mux = h2c_stat;
            CA_ACK:      c_mux = {7'd0, c_sta};
            default:     c_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_reg_q <= '0;
            c_src_q <= SRC_REG;
        end else if (cr) begin
            c_reg_q <= c_mux;
            c_src_q <= c_mb ? SRC_MBOX : SRC_REG;
        end
    end

    assign c_rdata = (c_src_q == SRC_MBOX) ? h2c_rd : c_reg_q;

    // R7: the host cannot alter the controller's control word
    a_r7_ctl_ro: assert property (@(posedge clk) disable iff (rst)
        (hw && (hreq.addr == HA_C2H_LO) && !(cw && creq.addr == CA_C2H_LO))
        |=> $stable(c2h_ctl.lo));

    // R8: a host status write raises the controller line next cycle
    a_r8_c_raise: assert property (@(posedge clk) disable iff (rst)
        (hw && hreq.addr == HA_H2C_STAT) |=> c_irq);

endmodule

// File: tb/hmbx_top_test.sv
`timescale 1ns/1ps
module hmbx_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_cs = 1'b0, h_we = 1'b0;
    logic [7:0] h_addr = '0, h_wdata = '0;
    logic [7:0] h_rdata;
    logic       h_irq;
    logic       c_en = 1'b0, c_we = 1'b0;
    logic [7:0] c_addr = '0, c_wdata = '0;
    logic [7:0] c_rdata;
    logic       c_irq;

    always #2 clk = ~clk;

    hmbx_top uut (
        .clk(clk), .rst(rst),
        .h_cs(h_cs), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .c_en(c_en), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_irq(c_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] hq_v[$];
    string      hq_t[$];
    logic [7:0] cq_v[$];
    string      cq_t[$];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    logic h_rd_v = 1'b0, c_rd_v = 1'b0;
    always @(posedge clk) begin
        h_rd_v <= h_cs & ~h_we & ~rst;
        c_rd_v <= c_en & ~c_we & ~rst;
    end

    always @(negedge clk) begin
        logic [7:0] e;
        string t;
        if (h_rd_v) begin
            if (hq_v.size() == 0) begin
                chk("host read with nothing queued", h_rdata, 8'hxx);
            end else begin
                e = hq_v.pop_front();
                t = hq_t.pop_front();
                chk(t, h_rdata, e);
            end
        end
        if (c_rd_v) begin
            if (cq_v.size() == 0) begin
                chk("controller read with nothing queued", c_rdata, 8'hxx);
            end else begin
                e = cq_v.pop_front();
                t = cq_t.pop_front();
                chk(t, c_rdata, e);
            end
        end
    end

    // drivers
    task automatic hwr(input logic [7:0] a, input logic [7:0] d);
        h_cs = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_cs = 1'b0; h_we = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, input logic [7:0] e, input string t);
        h_cs = 1'b1; h_we = 1'b0; h_addr = a;
        hq_v.push_back(e); hq_t.push_back(t);
        @(negedge clk);
        h_cs = 1'b0;
    endtask

    task automatic cwr(input logic [7:0] a, input logic [7:0] d);
        c_en = 1'b1; c_we = 1'b1; c_addr = a; c_wdata = d;
        @(negedge clk);
        c_en = 1'b0; c_we = 1'b0;
    endtask

    task automatic crd(input logic [7:0] a, input logic [7:0] e, input string t);
        c_en = 1'b1; c_we = 1'b0; c_addr = a;
        cq_v.push_back(e); cq_t.push_back(t);
        @(negedge clk);
        c_en = 1'b0;
    endtask

    task automatic both_wr(input logic [7:0] ha, input logic [7:0] hd,
                           input logic [7:0] ca, input logic [7:0] cd);
        h_cs = 1'b1; h_we = 1'b1; h_addr = ha; h_wdata = hd;
        c_en = 1'b1; c_we = 1'b1; c_addr = ca; c_wdata = cd;
        @(negedge clk);
        h_cs = 1'b0; h_we = 1'b0; c_en = 1'b0; c_we = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 h_irq low", {7'd0, h_irq}, 8'h00);
        chk("R1 c_irq low", {7'd0, c_irq}, 8'h00);
        hrd(8'h0A, 8'h00, "R1 mask/flag");
        hrd(8'h01, 8'h00, "R1 read index");
        hrd(8'h02, 8'h00, "R1 write index");
        hrd(8'h06, 8'h00, "R1 c2h control low");
        hrd(8'h08, 8'h00, "R1 c2h status");
        crd(8'h82, 8'h00, "R1 h2c control low");
        crd(8'h86, 8'h00, "R1 controller flag");

        // R2 sequential host-to-controller burst
        hwr(8'h00, 8'h11); hwr(8'h00, 8'h22); hwr(8'h00, 8'h33);
        hrd(8'h02, 8'h03, "R2 write index advanced");
        crd(8'd0, 8'h11, "R2 byte 0");
        crd(8'd1, 8'h22, "R2 byte 1");
        crd(8'd2, 8'h33, "R2 byte 2");

        // R3 sequential controller-to-host burst
        for (int i = 0; i < 4; i++) cwr(8'(i), 8'hA0 + 8'(i));
        for (int i = 0; i < 4; i++) hrd(8'h00, 8'hA0 + 8'(i), "R3 burst byte");
        hrd(8'h01, 8'h04, "R3 read index advanced");

        // R4 random access
        hwr(8'h01, 8'h02);
        hrd(8'h00, 8'hA2, "R4 random read");
        hrd(8'h01, 8'h03, "R4 read index after random read");
        hwr(8'h02, 8'd10);
        hwr(8'h00, 8'h5A);
        crd(8'd10, 8'h5A, "R4 random write");
        hrd(8'h02, 8'd11, "R4 write index after random write");

        // R5 wrap
        hwr(8'h02, 8'd60);
        hwr(8'h00, 8'h77); hwr(8'h00, 8'h78);
        crd(8'd60, 8'h77, "R5 last cell");
        crd(8'd0, 8'h78, "R5 wrapped write");
        hrd(8'h02, 8'h01, "R5 write index wrapped");
        cwr(8'd60, 8'hC6);
        hwr(8'h01, 8'd60);
        hrd(8'h00, 8'hC6, "R5 last cell read");
        hrd(8'h01, 8'h00, "R5 read index wrapped");

        // R6 out of range
        hwr(8'h02, 8'd62);
        hrd(8'h02, 8'd62, "R6 index readback");
        hwr(8'h00, 8'h99);
        hrd(8'h02, 8'h00, "R6 index from 62 to 0");
        crd(8'd0, 8'h78, "R6 cell 0 intact");
        crd(8'd1, 8'h22, "R6 cell 1 intact");
        crd(8'd62, 8'h00, "R6 controller out-of-range read");
        hwr(8'h01, 8'd63);
        hrd(8'h00, 8'h00, "R6 host out-of-range read");
        hrd(8'h01, 8'h00, "R6 read index from 63 to 0");

        // R7 control words
        hwr(8'h04, 8'h34); hwr(8'h05, 8'h12);
        crd(8'h82, 8'h34, "R7 h2c low");
        crd(8'h83, 8'h12, "R7 h2c high");
        cwr(8'h80, 8'hCD); cwr(8'h81, 8'hAB);
        hrd(8'h06, 8'hCD, "R7 c2h low");
        hrd(8'h07, 8'hAB, "R7 c2h high");
        hwr(8'h06, 8'hFF); hwr(8'h07, 8'hFF);
        hrd(8'h06, 8'hCD, "R7 host write to c2h low ignored");
        hrd(8'h07, 8'hAB, "R7 host write to c2h high ignored");

        // R8 / R9 / R10 host flag
        cwr(8'h84, 8'h5E);
        chk("R9 masked line stays low", {7'd0, h_irq}, 8'h00);
        hrd(8'h08, 8'h5E, "R8 c2h status byte");
        hrd(8'h0A, 8'h01, "R9 flag set while masked");
        hwr(8'h0A, 8'h04);
        chk("R9 unmask raises line", {7'd0, h_irq}, 8'h01);
        hrd(8'h0A, 8'h05, "R9 mask and flag");
        hwr(8'h0B, 8'h00);
        chk("R10 ack bit0 clear has no effect", {7'd0, h_irq}, 8'h01);
        hwr(8'h0B, 8'h01);
        chk("R10 ack clears line", {7'd0, h_irq}, 8'h00);
        hrd(8'h0A, 8'h04, "R10 flag cleared");
        both_wr(8'h0B, 8'h01, 8'h84, 8'h66);
        chk("R10 event wins over ack", {7'd0, h_irq}, 8'h01);
        hrd(8'h08, 8'h66, "R8 second status byte");
        hwr(8'h0B, 8'h01);
        chk("R10 ack after collision", {7'd0, h_irq}, 8'h00);
        hwr(8'h0A, 8'h00);
        cwr(8'h84, 8'h01);
        chk("R9 re-masked line low", {7'd0, h_irq}, 8'h00);
        hrd(8'h0A, 8'h01, "R9 flag polled while masked");
        hwr(8'h0A, 8'h04);
        chk("R9 pending flag shows on unmask", {7'd0, h_irq}, 8'h01);
        hwr(8'h0B, 8'h01);

        // R8 / R11 controller flag
        hwr(8'h09, 8'h3C);
        chk("R11 c_irq raised", {7'd0, c_irq}, 8'h01);
        crd(8'h85, 8'h3C, "R8 h2c status byte");
        crd(8'h86, 8'h01, "R11 flag read");
        cwr(8'h86, 8'h00);
        chk("R11 ack bit0 clear has no effect", {7'd0, c_irq}, 8'h01);
        cwr(8'h86, 8'h01);
        chk("R11 ack clears", {7'd0, c_irq}, 8'h00);
        both_wr(8'h09, 8'h3D, 8'h86, 8'h01);
        chk("R11 event wins over ack", {7'd0, c_irq}, 8'h01);
        cwr(8'h86, 8'h01);
        chk("R11 ack after collision", {7'd0, c_irq}, 8'h00);

        repeat (3) @(negedge clk);
        chk("host scoreboard drained", 8'(hq_v.size()), 8'h00);
        chk("controller scoreboard drained", 8'(cq_v.size()), 8'h00);
        summary();
    end

endmodule